// File: doc/BRIEF.md
# SPI DMA Address and Count Sequencer

This block is the address and count engine behind a pair of peripheral DMA channels, one for transmit and one for receive, that serve an SPI data port. The port raises a request when it holds a received word or can accept a new one. The sequencer takes that request itself and issues one memory strobe for each granted transfer. It then moves the channel's memory pointer forward and lowers the channel's transfer count by one.

The pointer step is set by the configuration. In variable peripheral selection every item is a 32-bit word, so the step is 4. In fixed selection an 8-bit width gives a step of 1 and a 9 to 16 bit width gives a step of 2. When the sequencer writes received data, any bits above the configured width are written as zero. Each direction also has a second "next" pointer and count pair, which lets software chain two buffers. The block reports four status flags: end of receive buffer, end of transmit buffer, receive buffer full and transmit buffer empty.

Top module: `spi_dma_seq`

## Requirements
- R1: With `cfg_var_sel`=0 and `cfg_bits`<=8, a granted transfer uses `mem_size`=0 (byte) and the channel pointer advances by 1.
- R2: With `cfg_var_sel`=0 and `cfg_bits` from 9 to 16, a granted transfer uses `mem_size`=1 (halfword) and the pointer advances by 2.
- R3: On a receive write in fixed selection, `mem_wdata` carries `rx_data` bits below the configured width, and every bit above that width is 0 (the byte case keeps bits 7:0 only).
- R4: With `cfg_var_sel`=1, a granted transfer uses `mem_size`=2 (word), passes all 32 bits of `rx_data`, and advances the pointer by 4, whatever `cfg_bits` is.
- R5: A request is granted only while that direction's main count is nonzero. Each grant lowers the count by 1, and a request made while the count is 0 produces no strobe.
- R6: `end_tx` or `end_rx` goes to 1 on the clock where that direction's last counted transfer is taken. It returns to 0 on the clock that accepts a software load of a nonzero main count for that direction.
- R7: When the main count reaches 0 and the next count is nonzero, the next pointer and count are copied into the main registers and the next pair is cleared. The following transfer uses the next pointer.
- R8: `rx_buf_full` is 1 exactly when both receive counts are 0. `tx_buf_empty` is 1 exactly when both transmit counts are 0.
- R9: When both directions request in the same cycle and both can be granted, receive gets the memory strobe (`mem_wr`, no `mem_rd`). Transmit is served on a later cycle.
- R10: After reset all pointers and counts are 0, no strobe is active, both end flags are 0 and both buffer flags are 1.
- R11: Software loads use `ld_sel` with bit 1 selecting the direction (1 receive, 0 transmit) and bit 0 selecting the next pair (1) or the main pair (0). A software load of a main pair takes precedence over a transfer or reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_var_sel | input | 1 | 1: variable peripheral selection (32-bit items) |
| cfg_bits | input | 5 | Configured data width, 8 to 16 |
| ld_valid | input | 1 | Software load strobe |
| ld_sel | input | 2 | Load target: bit 1 direction, bit 0 next pair |
| ld_ptr | input | AW | Pointer value to load |
| ld_cnt | input | CW | Count value to load |
| tx_req | input | 1 | Port can accept a transmit item |
| rx_req | input | 1 | Port holds a received item |
| rx_data | input | 32 | Received item |
| mem_rd | output | 1 | Memory read strobe (transmit transfer) |
| mem_wr | output | 1 | Memory write strobe (receive transfer) |
| mem_addr | output | AW | Byte address of the transfer |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_wdata | output | 32 | Zero-filled write data |
| end_tx | output | 1 | Transmit main buffer ended |
| end_rx | output | 1 | Receive main buffer ended |
| rx_buf_full | output | 1 | Both receive counts are 0 |
| tx_buf_empty | output | 1 | Both transmit counts are 0 |

## Verification
Two functions can meet in one cycle. The first meeting is the last counted transfer of a buffer together with the reload from the next pair. The bench provokes it by loading a main count of 1 and a nonzero next count and then holding the request high. It passes when the first strobe uses the old address, the strobe in the following cycle uses the next pointer, and the number of strobes equals the sum of the two counts. The second meeting is both directions requesting together. The bench raises both requests in one cycle and expects the write strobe first and the read strobe one cycle later.

// File: rtl/spi_dma_seq.sv
module spi_dma_seq #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_var_sel,
  input  logic [4:0]    cfg_bits,
  input  logic          ld_valid,
  input  logic [1:0]    ld_sel,
  input  logic [AW-1:0] ld_ptr,
  input  logic [CW-1:0] ld_cnt,
  input  logic          tx_req,
  input  logic          rx_req,
  input  logic [31:0]   rx_data,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  output logic          end_tx,
  output logic          end_rx,
  output logic          rx_buf_full,
  output logic          tx_buf_empty
);
  localparam int TX = 0;
  localparam int RX = 1;

  logic [AW-1:0] ptr  [2];
  logic [AW-1:0] nptr [2];
  logic [CW-1:0] cnt  [2];
  logic [CW-1:0] ncnt [2];
  logic [1:0]    endf;
  logic [1:0]    gnt;

  logic          narrow;
  logic [AW-1:0] step;
  logic [16:0]   wmask;

  assign narrow = (cfg_bits <= 5'd8);
  assign step   = cfg_var_sel ? AW'(4) : (narrow ? AW'(1) : AW'(2));
  assign wmask  = (17'h1 << cfg_bits) - 17'h1;

  assign gnt[RX] = rx_req && (cnt[RX] != '0);
  assign gnt[TX] = tx_req && (cnt[TX] != '0) && !gnt[RX];

  assign mem_wr   = gnt[RX];
  assign mem_rd   = gnt[TX];
  assign mem_addr = gnt[RX] ? ptr[RX] : ptr[TX];
  assign mem_size = cfg_var_sel ? 2'd2 : (narrow ? 2'd0 : 2'd1);

  always_comb begin
    if (cfg_var_sel)  mem_wdata = rx_data;
    else if (narrow)  mem_wdata = {24'h0, rx_data[7:0]};
    else              mem_wdata = {16'h0, rx_data[15:0] & wmask[15:0]};
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic wr_main, wr_next, last, reload;
    assign wr_main = ld_valid && (ld_sel == {d[0], 1'b0});
    assign wr_next = ld_valid && (ld_sel == {d[0], 1'b1});
    assign last    = gnt[d] && (cnt[d] == CW'(1));
    assign reload  = ((cnt[d] == '0) || last) && (ncnt[d] != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr[d]  <= '0;
        cnt[d]  <= '0;
        nptr[d] <= '0;
        ncnt[d] <= '0;
        endf[d] <= 1'b0;
      end else begin
        if (wr_main) begin
          ptr[d] <= ld_ptr;
          cnt[d] <= ld_cnt;
        end else if (reload) begin
          ptr[d] <= nptr[d];
          cnt[d] <= ncnt[d];
        end else if (gnt[d]) begin
          ptr[d] <= ptr[d] + step;
          cnt[d] <= cnt[d] - CW'(1);
        end

        if (wr_next) begin
          nptr[d] <= ld_ptr;
          ncnt[d] <= ld_cnt;
        end else if (reload && !wr_main) begin
          nptr[d] <= '0;
          ncnt[d] <= '0;
        end

        if (wr_main && (ld_cnt != '0)) endf[d] <= 1'b0;
        else if (last && !wr_main)     endf[d] <= 1'b1;
      end
    end
  end

  assign end_tx       = endf[TX];
  assign end_rx       = endf[RX];
  assign rx_buf_full  = (cnt[RX] == '0) && (ncnt[RX] == '0);
  assign tx_buf_empty = (cnt[TX] == '0) && (ncnt[TX] == '0);

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r9_rx_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && tx_req && mem_wr) |-> !mem_rd);

  a_r4_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && cfg_var_sel && cnt[RX] > CW'(1) && !ld_valid)
      |=> ptr[RX] == $past(ptr[RX]) + AW'(4));

  a_r6_end_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && cnt[TX] == CW'(1) && !(ld_valid && ld_sel == 2'b00)) |=> end_tx);

  a_r5_idle_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_buf_full && !ld_valid) |=> (!mem_wr && $stable(ptr[RX])));

  a_r7_next_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && cnt[TX] == CW'(1) && ncnt[TX] != '0 && !ld_valid)
      |=> (ncnt[TX] == '0 && ptr[TX] == $past(nptr[TX])));

endmodule

// File: tb/spi_dma_seq_tb.sv
module spi_dma_seq_tb;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_var_sel = 1'b0;
  logic [4:0]    cfg_bits = 5'd8;
  logic          ld_valid = 1'b0;
  logic [1:0]    ld_sel = 2'b00;
  logic [AW-1:0] ld_ptr = '0;
  logic [CW-1:0] ld_cnt = '0;
  logic          tx_req = 1'b0;
  logic          rx_req = 1'b0;
  logic [31:0]   rx_data = '0;
  logic          mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [31:0]   mem_wdata;
  logic          end_tx, end_rx, rx_buf_full, tx_buf_empty;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  spi_dma_seq #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_var_sel(cfg_var_sel), .cfg_bits(cfg_bits),
    .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_ptr(ld_ptr), .ld_cnt(ld_cnt),
    .tx_req(tx_req), .rx_req(rx_req), .rx_data(rx_data),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .end_tx(end_tx), .end_rx(end_rx),
    .rx_buf_full(rx_buf_full), .tx_buf_empty(tx_buf_empty)
  );

  // {var_sel, bits, rx_data, step, size, expected wdata}
  typedef struct packed {
    logic        vs;
    logic [4:0]  bits;
    logic [31:0] data;
    logic [31:0] step;
    logic [1:0]  size;
    logic [31:0] wdata;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 5'd8,  32'hABCD_1234, 32'd1, 2'd0, 32'h0000_0034},
    '{1'b0, 5'd12, 32'hFFFF_FFFF, 32'd2, 2'd1, 32'h0000_0FFF},
    '{1'b0, 5'd16, 32'h1234_9876, 32'd2, 2'd1, 32'h0000_9876},
    '{1'b0, 5'd9,  32'hFFFF_03FF, 32'd2, 2'd1, 32'h0000_01FF},
    '{1'b1, 5'd8,  32'hDEAD_BEEF, 32'd4, 2'd2, 32'hDEAD_BEEF},
    '{1'b1, 5'd16, 32'h0F00_00A5, 32'd4, 2'd2, 32'h0F00_00A5}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] sel, input logic [31:0] p, input logic [15:0] c);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = sel; ld_ptr = p; ld_cnt = c;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R10 strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
    chk("R10 end flags", {30'd0, end_tx, end_rx}, 32'd0);
    chk("R10 buffer flags", {30'd0, rx_buf_full, tx_buf_empty}, 32'd3);

    // Step-size table: R1 R2 R3 R4
    for (int i = 0; i < 6; i++) begin
      load(2'b10, 32'h1000 + i * 32'h100, 16'd3);
      cfg_var_sel = VECS[i].vs; cfg_bits = VECS[i].bits;
      rx_data = VECS[i].data; rx_req = 1'b1;
      #5;
      chk("R1 R2 R4 first addr", mem_addr, 32'h1000 + i * 32'h100);
      chk("R1 R2 R4 size", {30'd0, mem_size}, {30'd0, VECS[i].size});
      chk("R3 R4 zero-filled data", mem_wdata, VECS[i].wdata);
      @(negedge clk); #5;
      chk("R1 R2 R4 stepped addr", mem_addr, 32'h1000 + i * 32'h100 + VECS[i].step);
      rx_req = 1'b0;
    end

    // R5 R6: drain a two-item transmit buffer
    cfg_var_sel = 1'b0; cfg_bits = 5'd8;
    load(2'b00, 32'h200, 16'd2);
    chk("R8 tx not empty", {31'd0, tx_buf_empty}, 32'd0);
    tx_req = 1'b1;
    #5; chk("R5 tx first", {31'd0, mem_rd}, 32'd1);
    chk("R5 tx addr", mem_addr, 32'h200);
    @(negedge clk); #5;
    chk("R5 tx second addr", mem_addr, 32'h201);
    chk("R6 end low before last", {31'd0, end_tx}, 32'd0);
    @(negedge clk); #5;
    chk("R5 no strobe at zero count", {31'd0, mem_rd}, 32'd0);
    chk("R6 end raised", {31'd0, end_tx}, 32'd1);
    chk("R8 tx empty", {31'd0, tx_buf_empty}, 32'd1);
    tx_req = 1'b0;
    load(2'b00, 32'h300, 16'd0);
    chk("R6 zero load keeps end", {31'd0, end_tx}, 32'd1);
    load(2'b00, 32'h300, 16'd1);
    chk("R6 nonzero load clears end", {31'd0, end_tx}, 32'd0);
    tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;

    // R7: last transfer and reload in the same cycle
    load(2'b00, 32'h400, 16'd1);
    load(2'b01, 32'h500, 16'd2);
    tx_req = 1'b1;
    #5; chk("R7 old buffer addr", mem_addr, 32'h400);
    @(negedge clk); #5;
    chk("R7 next pointer used", mem_addr, 32'h500);
    chk("R7 strobe continues", {31'd0, mem_rd}, 32'd1);
    chk("R6 end set on reload", {31'd0, end_tx}, 32'd1);
    @(negedge clk); #5;
    chk("R7 next advanced", mem_addr, 32'h501);
    @(negedge clk); #5;
    chk("R7 stops after both", {31'd0, mem_rd}, 32'd0);
    chk("R8 tx empty after chain", {31'd0, tx_buf_empty}, 32'd1);
    tx_req = 1'b0;

    // R9 R11: simultaneous requests, receive first
    cfg_var_sel = 1'b1;
    load(2'b10, 32'h600, 16'd1);
    load(2'b00, 32'h700, 16'd1);
    chk("R8 rx not full", {31'd0, rx_buf_full}, 32'd0);
    rx_req = 1'b1; tx_req = 1'b1;
    #5;
    chk("R9 rx wins", {30'd0, mem_wr, mem_rd}, 32'd2);
    chk("R9 rx addr", mem_addr, 32'h600);
    @(negedge clk); #5;
    chk("R9 tx served next", {30'd0, mem_wr, mem_rd}, 32'd1);
    chk("R9 tx addr", mem_addr, 32'h700);
    chk("R8 rx full", {31'd0, rx_buf_full}, 32'd1);
    chk("R6 rx end", {31'd0, end_rx}, 32'd1);
    @(negedge clk);
    rx_req = 1'b0; tx_req = 1'b0;

    // R11: main load wins over a same-cycle transfer
    load(2'b10, 32'h800, 16'd2);
    rx_req = 1'b1;
    ld_valid = 1'b1; ld_sel = 2'b10; ld_ptr = 32'h900; ld_cnt = 16'd1;
    #5; chk("R11 strobe before load", mem_addr, 32'h800);
    @(negedge clk); ld_valid = 1'b0; #5;
    chk("R11 load overrides step", mem_addr, 32'h900);
    @(negedge clk); #5;
    chk("R5 stops after loaded count", {31'd0, mem_wr}, 32'd0);
    rx_req = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule